// File: doc/BRIEF.md
# Fixed Off-Time Mixed-Decay Current Chopper

This block regulates the current of one motor winding by switching a single H-bridge. It turns the bridge on in the commanded polarity and keeps driving until an external comparator reports that the sensed current has reached the trip level. A fixed off-time then follows. During the off-time the winding current decays through either the two low-side switches (slow decay) or the opposite diagonal (fast decay). In mixed decay the off-time opens with a fast segment and finishes in slow decay.

The comparator is ignored for a blanking window at the start of every drive interval, so switching transients cannot end it early. Whenever the bridge moves from one conducting state to another, all four switches are held off for a dead time. The decay request is sampled at the moment of the trip: it is high while the commanded current magnitude is falling and selects mixed decay; otherwise slow decay is used. Dropping enable or raising fault turns every switch off at once. Once both clear, the block starts again with a dead interval followed by drive.

Top module: `mixed_decay_chopper`

## Requirements
- R1: While reset is asserted, and afterwards while `en_i` is low, `gate_o` is 4'b0000. The gate bits are {leg A high, leg A low, leg B high, leg B low}.
- R2: After a clock edge that samples `en_i`=1 and `fault_i`=0 in the idle state, `gate_o` is 0 for 2 cycles and then shows the drive code. The drive code is 4'b1001 when the latched direction is 1 and 4'b0110 when it is 0.
- R3: `trip_i` is ignored during the first 8 cycles of every drive interval. A `trip_i`=1 sampled in drive cycle 8 or later (counting from 0) ends that drive interval at the same edge.
- R4: When `falling_i`=0 at the trip edge, the off-time is 2 cycles of 0, then 32 cycles of slow decay (4'b0101), then 2 cycles of 0, and then drive again.
- R5: When `falling_i`=1 at the trip edge, the off-time is 2 cycles of 0, then 10 cycles of fast decay, 2 cycles of 0, 22 cycles of 4'b0101, 2 cycles of 0, and then drive. Fast decay is the opposite diagonal of the drive code: 4'b0110 for direction 1 and 4'b1001 for direction 0.
- R6: Changes of `trip_i` and `falling_i` during dead time or the off-time have no effect on the sequence.
- R7: `dir_i` is latched at the edge that enters drive. Changing it during drive or the off-time has no effect until the next drive interval.
- R8: In any cycle with `en_i`=0 or `fault_i`=1, `gate_o` is 0 in that same cycle. Once both clear, the block restarts as in R2.
- R9: The high and low switch of a leg are never on together. Between two different non-zero codes `gate_o` is 0 for at least 2 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Bridge enable |
| fault_i | input | 1 | Fault present; forces all switches off |
| trip_i | input | 1 | Comparator: sensed current at or above trip level |
| falling_i | input | 1 | Decay request: commanded magnitude falling (mixed decay) |
| dir_i | input | 1 | Drive polarity, latched on drive entry |
| gate_o | output | 4 | Gate commands {A high, A low, B high, B low} |

## Verification
The hardest case to reach is a trip that lands exactly at the end of the blanking window while the polarity and decay request change under the block. The bench holds the comparator high through whole drive intervals, so each trip falls on the first cycle after blanking. It toggles the decay request and the direction during the dead, fast and slow segments and checks that the sequence ignores them. It also pulses fault and enable in the middle of decay segments and checks the restart.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [2:0] {
    PH_OFF   = 3'd0,
    PH_DEAD  = 3'd1,
    PH_DRIVE = 3'd2,
    PH_FAST  = 3'd3,
    PH_SLOW  = 3'd4
  } phase_e;

  localparam int unsigned GATE_W = 4;
  localparam int unsigned LEGS   = 2;
endpackage

// File: rtl/chop_seq.sv
module chop_seq
  import chop_pkg::*;
#(
  parameter int unsigned OFF_CYC   = 32,
  parameter int unsigned DEAD_CYC  = 2,
  parameter int unsigned BLANK_CYC = 8
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   run_i,
  input  logic   trip_i,
  input  logic   falling_i,
  input  logic   dir_i,
  output phase_e phase_o,
  output logic   dir_o
);
  // fast segment = 31.25% (5/16) of off-time, rounded to nearest
  localparam int unsigned FAST_CYC = (OFF_CYC * 5 + 8) / 16;
  localparam int unsigned SLOW_MIX = OFF_CYC - FAST_CYC;
  localparam int unsigned MAX_A    = (OFF_CYC > BLANK_CYC) ? OFF_CYC : BLANK_CYC;
  localparam int unsigned MAX_C    = (MAX_A > DEAD_CYC) ? MAX_A : DEAD_CYC;
  localparam int unsigned CW       = $clog2(MAX_C + 1);

  localparam logic [CW-1:0] DEAD_END = CW'(DEAD_CYC - 1);
  localparam logic [CW-1:0] FAST_END = CW'(FAST_CYC - 1);
  localparam logic [CW-1:0] SMIX_END = CW'(SLOW_MIX - 1);
  localparam logic [CW-1:0] SFUL_END = CW'(OFF_CYC - 1);
  localparam logic [CW-1:0] BLANK_N  = CW'(BLANK_CYC);

  phase_e        phase_q, next_q;
  logic [CW-1:0] cnt_q;
  logic          mix_q, dir_q;
  logic [CW-1:0] slow_end;

  assign slow_end = mix_q ? SMIX_END : SFUL_END;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_OFF;
      next_q  <= PH_DRIVE;
      cnt_q   <= '0;
      mix_q   <= 1'b0;
      dir_q   <= 1'b0;
    end else if (!run_i) begin
      phase_q <= PH_OFF;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_OFF: begin
          phase_q <= PH_DEAD;
          next_q  <= PH_DRIVE;
          cnt_q   <= '0;
        end
        PH_DEAD: begin
          if (cnt_q == DEAD_END) begin
            phase_q <= next_q;
            cnt_q   <= '0;
            if (next_q == PH_DRIVE) dir_q <= dir_i;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_DRIVE: begin
          if (cnt_q >= BLANK_N && trip_i) begin
            phase_q <= PH_DEAD;
            next_q  <= falling_i ? PH_FAST : PH_SLOW;
            mix_q   <= falling_i;
            cnt_q   <= '0;
          end else if (cnt_q < BLANK_N) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_FAST: begin
          if (cnt_q == FAST_END) begin
            phase_q <= PH_DEAD;
            next_q  <= PH_SLOW;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_SLOW: begin
          if (cnt_q == slow_end) begin
            phase_q <= PH_DEAD;
            next_q  <= PH_DRIVE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          phase_q <= PH_OFF;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign phase_o = phase_q;
  assign dir_o   = dir_q;
endmodule

// File: rtl/chop_gate_enc.sv
module chop_gate_enc
  import chop_pkg::*;
(
  input  phase_e             phase_i,
  input  logic               dir_i,
  input  logic               run_i,
  output logic [GATE_W-1:0]  gate_o
);
  logic is_drive, is_fast, is_slow;

  assign is_drive = (phase_i == PH_DRIVE);
  assign is_fast  = (phase_i == PH_FAST);
  assign is_slow  = (phase_i == PH_SLOW);

  // leg 0 = A (bits 3:2), leg 1 = B (bits 1:0); B sees inverted polarity
  for (genvar l = 0; l < LEGS; l++) begin : g_leg
    logic pol, hi, lo;
    assign pol = (l == 0) ? dir_i : ~dir_i;
    assign hi  = run_i & ((is_drive & pol) | (is_fast & ~pol));
    assign lo  = run_i & ((is_drive & ~pol) | (is_fast & pol) | is_slow);
    assign gate_o[GATE_W-1-2*l]   = hi;
    assign gate_o[GATE_W-2-2*l]   = lo;
  end
endmodule

// File: rtl/mixed_decay_chopper.sv
module mixed_decay_chopper
  import chop_pkg::*;
#(
  parameter int unsigned OFF_CYC   = 32,
  parameter int unsigned DEAD_CYC  = 2,
  parameter int unsigned BLANK_CYC = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       fault_i,
  input  logic       trip_i,
  input  logic       falling_i,
  input  logic       dir_i,
  output logic [3:0] gate_o
);
  phase_e phase;
  logic   dir_l;
  logic   run;

  assign run = en_i & ~fault_i;

  chop_seq #(
    .OFF_CYC  (OFF_CYC),
    .DEAD_CYC (DEAD_CYC),
    .BLANK_CYC(BLANK_CYC)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .trip_i   (trip_i),
    .falling_i(falling_i),
    .dir_i    (dir_i),
    .phase_o  (phase),
    .dir_o    (dir_l)
  );

  chop_gate_enc u_enc (
    .phase_i(phase),
    .dir_i  (dir_l),
    .run_i  (run),
    .gate_o (gate_o)
  );
endmodule

// File: rtl/chop_chk.sv
module chop_chk
  import chop_pkg::*;
#(
  parameter int unsigned OFF_CYC   = 32,
  parameter int unsigned BLANK_CYC = 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       fault_i,
  input phase_e     phase_i,
  input logic [3:0] gate_i
);
  localparam int unsigned FAST_CYC = (OFF_CYC * 5 + 8) / 16;

  logic ok;
  int unsigned drv_cnt, fst_cnt;

  assign ok = en_i & ~fault_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_cnt <= 0;
      fst_cnt <= 0;
    end else begin
      drv_cnt <= (phase_i == PH_DRIVE) ? ((drv_cnt < 1000) ? drv_cnt + 1 : drv_cnt) : 0;
      fst_cnt <= (phase_i == PH_FAST)  ? ((fst_cnt < 1000) ? fst_cnt + 1 : fst_cnt) : 0;
    end
  end

  a_r3_blank_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_DRIVE && drv_cnt < BLANK_CYC && ok) |=> phase_i == PH_DRIVE);

  a_r5_fast_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_FAST && fst_cnt < FAST_CYC - 1 && ok) |=> phase_i == PH_FAST);

  a_r5_fast_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_FAST && fst_cnt == FAST_CYC - 1 && ok) |=> phase_i == PH_DEAD);

  a_r8_kill_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || fault_i) |=> gate_i == 4'b0000);

  a_r9_leg_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_i[3] && gate_i[2]));

  a_r9_leg_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_i[1] && gate_i[0]));

  a_r9_no_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_i != 4'b0000 && $past(gate_i) != 4'b0000) |-> gate_i == $past(gate_i));

  a_r9_dead_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(gate_i, 2) != 4'b0000 && $past(gate_i) == 4'b0000) |-> gate_i == 4'b0000);
endmodule

bind mixed_decay_chopper chop_chk #(
  .OFF_CYC  (OFF_CYC),
  .BLANK_CYC(BLANK_CYC)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .fault_i(fault_i),
  .phase_i(phase),
  .gate_i (gate_o)
);

// File: tb/mixed_decay_chopper_tb.sv
`timescale 1ns/1ps
module mixed_decay_chopper_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0, fault = 1'b0, trip = 1'b0, falling = 1'b0, dir = 1'b1;
  logic [3:0] gate;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #5 clk = ~clk;

  mixed_decay_chopper u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .en_i     (en),
    .fault_i  (fault),
    .trip_i   (trip),
    .falling_i(falling),
    .dir_i    (dir),
    .gate_o   (gate)
  );

  // behavioural reference: schedule of upcoming gate codes
  logic [3:0] plan[$];
  bit         running, in_drive, dirl;
  int         age;
  logic [3:0] mcur;

  function automatic logic [3:0] drv_code(bit d);
    return d ? 4'b1001 : 4'b0110;
  endfunction
  function automatic logic [3:0] fast_code(bit d);
    return d ? 4'b0110 : 4'b1001;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni || !en || fault) begin
      plan.delete();
      running  = 0;
      in_drive = 0;
      mcur     = 4'b0000;
    end else if (!running) begin
      running  = 1;
      in_drive = 0;
      plan.push_back(4'b0000);
      plan.push_back(4'b0000);
      mcur = plan.pop_front();
    end else if (in_drive) begin
      if (age >= 8 && trip) begin
        plan.push_back(4'b0000); plan.push_back(4'b0000);
        if (falling) begin
          for (int i = 0; i < 10; i++) plan.push_back(fast_code(dirl));
          plan.push_back(4'b0000); plan.push_back(4'b0000);
          for (int i = 0; i < 22; i++) plan.push_back(4'b0101);
        end else begin
          for (int i = 0; i < 32; i++) plan.push_back(4'b0101);
        end
        plan.push_back(4'b0000); plan.push_back(4'b0000);
        in_drive = 0;
        mcur = plan.pop_front();
      end else begin
        if (age < 8) age++;
        mcur = drv_code(dirl);
      end
    end else if (plan.size() > 0) begin
      mcur = plan.pop_front();
    end else begin
      in_drive = 1;
      age      = 0;
      dirl     = dir;
      mcur     = drv_code(dirl);
    end
  end

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t gate=%b expected=%b", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      check(cur_req, gate, (!en || fault) ? 4'b0000 : mcur);
      checks++;
      if ((gate[3] && gate[2]) || (gate[1] && gate[0])) begin
        fails++;
        $display("FAIL R9 leg overlap gate=%b expected=no leg with both on", gate);
      end
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset and idle
    #2;
    check("R1", gate, 4'b0000);
    tick(3);
    rst_ni = 1'b1;
    tick(4);
    @(negedge clk);
    check("R1", gate, 4'b0000);
    @(posedge clk); #1;

    // R2 + R3 + R4: start forward, comparator held high, slow decay
    cur_req = "R2";
    en = 1'b1; dir = 1'b1; trip = 1'b1; falling = 1'b0;
    tick(3);
    @(negedge clk);
    check("R2", gate, 4'b1001);
    @(posedge clk); #1;
    cur_req = "R3";
    tick(7);
    @(negedge clk);
    check("R3", gate, 4'b1001);  // drive cycle 8, trip accepted at next edge
    @(posedge clk); #1;
    cur_req = "R4";
    tick(2);
    @(negedge clk);
    check("R4", gate, 4'b0101);
    @(posedge clk); #1;
    tick(40);

    // R5 + R6: mixed decay, toggle inputs during off-time
    cur_req = "R5";
    falling = 1'b1;
    tick(12);
    cur_req = "R6";
    for (int i = 0; i < 30; i++) begin
      falling = ~falling;
      trip    = ~trip;
      tick(1);
    end
    falling = 1'b1; trip = 1'b1;
    tick(60);

    // R7: direction change while driving
    cur_req = "R7";
    trip = 1'b0; dir = 1'b0;
    tick(5);
    dir = 1'b1;
    tick(5);
    dir = 1'b0;
    trip = 1'b1;
    tick(3);
    dir = 1'b1;       // changes during fast segment
    tick(50);
    dir = 1'b0;
    tick(60);

    // R8: fault pulse in slow segment, enable drop, restart reverse
    cur_req = "R8";
    falling = 1'b0;
    tick(20);
    fault = 1'b1;
    @(negedge clk);
    check("R8", gate, 4'b0000);
    @(posedge clk); #1;
    fault = 1'b0; dir = 1'b0;
    tick(3);
    @(negedge clk);
    check("R8", gate, 4'b0110);
    @(posedge clk); #1;
    tick(15);
    en = 1'b0;
    tick(4);
    en = 1'b1;
    tick(80);

    // R9: overlap and dead gaps checked every cycle above
    cur_req = "R9";
    falling = 1'b1; dir = 1'b1;
    tick(100);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule